// File: doc/BRIEF.md
# I2C Bus Clock and Bit-Slot Timing Generator

This block produces the serial clock of an I2C master and decides when the data line is driven and when it is sampled. It runs from a fixed 24 MHz block clock. Two 32-bit timing words configure it. The upper half of each word is a phase length in block-clock cycles. The lower half is the offset inside that phase at which a data strobe fires. Software computes these words from the wanted bus rate. For a rate between 12 kHz and 540 kHz (100 kHz by default), it takes base = (24 MHz / rate − 38) / 2, sets the high length to base + 3 and the low length to base − 3, and then sets the sample offset to three quarters of the high length and the drive offset to one quarter of the low length.

A byte engine drives the block one slot at a time through a command handshake. A slot is a data bit, a START or a STOP. For a data bit, the engine hands over the bit to transmit. At the end of the slot it gets back the level read from the bus. Releasing the line and transmitting 1 is how a bit is received.

Both bus lines are open drain. An output enable of 1 pulls the line low. The clock line is read back, and the high phase only counts while the line is seen high, so a slave that holds the clock low stretches the slot.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, both line enables (`scl_oe`, `sda_oe`) are 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: In `hi_cfg`, bits 31:16 give the high length H and bits 15:0 the sample offset. In `lo_cfg`, bits 31:16 give the low length L and bits 15:0 the drive offset. A bit slot pulls SCL low for L cycles and then releases it for H counted cycles. A length of 0 acts as 1.
- R3: `cmd_kind` 0 is a data bit, 1 is START and 2 is STOP; 3 acts as a data bit. In a data-bit slot, `sda_oe` takes the value inverse of `cmd_bit` after drive-offset + 1 cycles of the low phase.
- R4: A data-bit slot ends by pulling SCL low with a one-cycle `rsp_valid`. Its `rsp_bit` is the `sda_in` level in the counted high cycle whose index equals the sample offset. START and STOP return `rsp_bit` 0.
- R5: In the high, setup and hold phases, the counter advances only in cycles where `scl_in` is high. A stretch of S cycles lengthens the phase by exactly S.
- R6: START from an idle bus keeps SDA released and SCL released for H cycles, then pulls SDA low for H cycles, then pulls SCL low and parks with `rsp_valid`.
- R7: START from the parked state (repeated start) first runs a low phase of L cycles that releases SDA at the drive offset, then continues as in R6.
- R8: STOP runs a low phase that pulls SDA low at the drive offset. It then releases SCL for H cycles, releases SDA, and waits H more cycles. It ends idle with both lines released, `rsp_valid` 1 and `cmd_ready` 1.
- R9: A data-bit or STOP command given while the bus is idle is consumed without effect: both lines stay released and no `rsp_valid` follows.
- R10: `cmd_ready` is 1 only when the bus is idle or parked; it is 0 for the whole of a running slot.
- R11: During the high phase of a data bit, `sda_oe` does not change.
- R12: `rsp_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_cfg | input | 32 | High length [31:16], sample offset [15:0] |
| lo_cfg | input | 32 | Low length [31:16], drive offset [15:0] |
| cmd_valid | input | 1 | Slot command offered |
| cmd_kind | input | 2 | 0 bit, 1 START, 2 STOP, 3 bit |
| cmd_bit | input | 1 | Bit to transmit for a data slot |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| rsp_valid | output | 1 | One-cycle pulse at slot end |
| rsp_bit | output | 1 | Sampled data bit of the ended slot |
| scl_in | input | 1 | Observed clock line level |
| sda_in | input | 1 | Observed data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Two events can land on the same clock edge. The sample strobe can coincide with the end of the high phase and the response, and the drive strobe can coincide with the end of the low phase. Directed cases set the sample offset to H − 1, and use a zero low length with a zero drive offset, the latter being the 540 kHz setting. The bench model sets the data line to the wanted level only in the counted high cycle whose index equals the offset and to the opposite level everywhere else. A correct `rsp_bit` therefore shows that the final-cycle sample was taken, and the measured drive delay shows that the change happened at the single low cycle. Random rates and random stretch lengths also place stretch cycles right before the sample cycle.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*CW-1:0] hi_cfg,
  input  logic [2*CW-1:0] lo_cfg,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_bit,
  output logic          cmd_ready,
  output logic          rsp_valid,
  output logic          rsp_bit,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [1:0] K_START = 2'd1;
  localparam logic [1:0] K_STOP  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_PARK, S_LOW, S_HIGH, S_SETUP, S_HOLD} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  kind;
  logic        bit_q, smp;

  wire [CW-1:0] hi_len = hi_cfg[2*CW-1:CW];
  wire [CW-1:0] rx_off = hi_cfg[CW-1:0];
  wire [CW-1:0] lo_len = lo_cfg[2*CW-1:CW];
  wire [CW-1:0] tx_off = lo_cfg[CW-1:0];

  wire [CW:0] cnt_nx = {1'b0, cnt} + 1'b1;
  wire lo_end   = cnt_nx >= {1'b0, lo_len};
  wire hi_end   = cnt_nx >= {1'b0, hi_len};
  wire is_start = kind == K_START;
  wire is_stop  = kind == K_STOP;
  wire take     = cmd_valid && cmd_ready;
  wire at_rx    = cnt == rx_off;

  assign cmd_ready = (st == S_IDLE) || (st == S_PARK);
  assign scl_oe    = (st == S_LOW) || (st == S_PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      kind      <= '0;
      bit_q     <= 1'b0;
      smp       <= 1'b0;
      sda_oe    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_bit   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (take && cmd_kind == K_START) begin
          kind <= cmd_kind;
          cnt  <= '0;
          st   <= S_SETUP;
        end
        S_PARK: if (take) begin
          kind  <= cmd_kind;
          bit_q <= cmd_bit;
          cnt   <= '0;
          st    <= S_LOW;
        end
        S_LOW: begin
          if (cnt == tx_off) sda_oe <= is_start ? 1'b0 : (is_stop ? 1'b1 : ~bit_q);
          if (lo_end) begin
            cnt <= '0;
            st  <= (is_start || is_stop) ? S_SETUP : S_HIGH;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        S_HIGH: if (scl_in) begin
          if (at_rx) smp <= sda_in;
          if (hi_end) begin
            rsp_valid <= 1'b1;
            rsp_bit   <= at_rx ? sda_in : smp;
            cnt       <= '0;
            st        <= S_PARK;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        S_SETUP: if (scl_in) begin
          if (hi_end) begin
            sda_oe <= is_start;
            cnt    <= '0;
            st     <= S_HOLD;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        S_HOLD: if (scl_in) begin
          if (hi_end) begin
            rsp_valid <= 1'b1;
            rsp_bit   <= 1'b0;
            cnt       <= '0;
            st        <= is_start ? S_PARK : S_IDLE;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt,
  input logic          scl_in,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          rsp_valid,
  input logic          cmd_ready
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_HIGH = 3'd3;

  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HIGH && $past(st) == C_HIGH) |-> $stable(sda_oe));

  a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HIGH && !scl_in) |=> (st == C_HIGH && $stable(cnt)));

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> (!scl_oe && !sda_oe));

  a_r10_rsp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .scl_in(scl_in),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .rsp_valid(rsp_valid), .cmd_ready(cmd_ready)
);

// File: tb/i2c_scl_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] hi_cfg = '0, lo_cfg = '0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic hold = 1'b0, slv = 1'b1;
  wire cmd_ready, rsp_valid, rsp_bit, scl_oe, sda_oe;
  wire scl_in = ~scl_oe & ~hold;
  wire sda_in = ~sda_oe & slv;
  int n_run = 0, n_fail = 0;
  int H, L, RX, TX;

  always #2.5 clk = ~clk;

  i2c_scl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .hi_cfg(hi_cfg), .lo_cfg(lo_cfg),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_bit(rsp_bit),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_raw(input int h, input int rx, input int l, input int tx);
    hi_cfg = {h[15:0], rx[15:0]};
    lo_cfg = {l[15:0], tx[15:0]};
    H = (h == 0) ? 1 : h;
    L = (l == 0) ? 1 : l;
    RX = rx;
    TX = tx;
  endtask

  function automatic int base_of(input int rate);
    int r;
    r = (rate > 540000) ? 540000 : ((rate < 12000) ? 12000 : rate);
    return (24000000 / r - 38) / 2;
  endfunction

  task automatic set_rate(input int rate);
    int b, h, l;
    b = base_of(rate);
    h = b + 3;
    l = b - 3;
    set_raw(h, h * 3 / 4, l, l / 4);
  endtask

  task automatic send(input logic [1:0] k, input bit b);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bit_slot(input bit b, input bit v, input int s);
    logic old;
    int lc, bc, k, tot, st, unst, busy;
    old = sda_oe; lc = 0; bc = 0; k = 0; tot = 0; st = s; unst = 0; busy = 0;
    send(2'b00, b);
    while (scl_oe === 1'b1 && lc < 70000) begin
      lc++;
      if (sda_oe !== ~b) bc++;
      if (cmd_ready) busy++;
      @(negedge clk);
    end
    chk(lc == L, "R2 low length", lc, L);
    if (old !== ~b) chk(bc == TX + 1, "R3 drive offset", bc, TX + 1);
    else chk(bc == 0, "R3 level kept", bc, 0);
    while (scl_oe === 1'b0 && tot < 100000) begin
      if (st > 0) begin hold = 1'b1; st--; end else hold = 1'b0;
      slv = (k == RX) ? v : ~v;
      if (sda_oe !== ~b) unst++;
      if (cmd_ready) busy++;
      if (!hold) k++;
      tot++;
      @(negedge clk);
    end
    hold = 1'b0; slv = 1'b1;
    chk(k == H, "R2 high length", k, H);
    chk(tot == H + s, "R5 stretch length", tot, H + s);
    chk(unst == 0, "R11 sda steady in high", unst, 0);
    chk(busy == 0, "R10 ready during slot", busy, 0);
    chk(rsp_valid === 1'b1, "R4 response pulse", rsp_valid, 1);
    chk(rsp_bit === (b & v), "R4 sampled bit", rsp_bit, b & v);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 single cycle response", rsp_valid, 0);
  endtask

  task automatic start_seq(input bit from_park);
    logic old;
    int lc, bc, su, hd;
    old = sda_oe; lc = 0; bc = 0; su = 0; hd = 0;
    send(2'b01, 1'b0);
    if (from_park) begin
      while (scl_oe === 1'b1 && lc < 70000) begin
        lc++;
        if (sda_oe !== 1'b0) bc++;
        @(negedge clk);
      end
      chk(lc == L, "R7 low length", lc, L);
      if (old) chk(bc == TX + 1, "R7 release offset", bc, TX + 1);
    end
    while (scl_oe === 1'b0 && sda_oe === 1'b0 && su < 70000) begin su++; @(negedge clk); end
    chk(su == H, "R6 setup length", su, H);
    while (scl_oe === 1'b0 && sda_oe === 1'b1 && hd < 70000) begin hd++; @(negedge clk); end
    chk(hd == H, "R6 hold length", hd, H);
    chk(scl_oe && sda_oe && rsp_valid && rsp_bit == 1'b0, "R6 parked after start",
        {scl_oe, sda_oe, rsp_valid, rsp_bit}, 4'b1110);
  endtask

  task automatic stop_seq();
    logic old;
    int lc, bc, su, hd;
    old = sda_oe; lc = 0; bc = 0; su = 0; hd = 0;
    send(2'b10, 1'b0);
    while (scl_oe === 1'b1 && lc < 70000) begin
      lc++;
      if (sda_oe !== 1'b1) bc++;
      @(negedge clk);
    end
    chk(lc == L, "R8 low length", lc, L);
    if (!old) chk(bc == TX + 1, "R8 pull offset", bc, TX + 1);
    while (!scl_oe && sda_oe === 1'b1 && !rsp_valid && su < 70000) begin su++; @(negedge clk); end
    chk(su == H, "R8 setup length", su, H);
    while (!scl_oe && sda_oe === 1'b0 && !rsp_valid && hd < 70000) begin hd++; @(negedge clk); end
    chk(hd == H, "R8 hold length", hd, H);
    chk(rsp_valid && !scl_oe && !sda_oe && cmd_ready, "R8 idle after stop",
        {rsp_valid, scl_oe, sda_oe, cmd_ready}, 4'b1001);
  endtask

  task automatic idle_ignore(input logic [1:0] k);
    int bad;
    bad = 0;
    send(k, 1'b0);
    repeat (20) begin
      if (scl_oe || sda_oe || rsp_valid || !cmd_ready) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 ignored while idle", bad, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    set_rate(100000);
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !rsp_valid, "R1 reset state",
        {scl_oe, sda_oe, cmd_ready, rsp_valid}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !rsp_valid, "R1 after release",
        {scl_oe, sda_oe, cmd_ready, rsp_valid}, 4'b0010);
    idle_ignore(2'b00);
    idle_ignore(2'b10);

    start_seq(1'b0);
    bit_slot(1'b1, 1'b0, 0);
    bit_slot(1'b1, 1'b1, 0);
    bit_slot(1'b0, 1'b1, 5);
    bit_slot(1'b1, 1'b1, 7);
    start_seq(1'b1);
    bit_slot(1'b0, 1'b0, 0);
    stop_seq();

    set_raw(10, 9, 8, 0);
    start_seq(1'b0);
    bit_slot(1'b1, 1'b1, 0);
    bit_slot(1'b1, 1'b0, 3);
    bit_slot(1'b0, 1'b1, 0);
    stop_seq();

    set_rate(540000);
    start_seq(1'b0);
    bit_slot(1'b0, 1'b1, 2);
    bit_slot(1'b1, 1'b0, 0);
    start_seq(1'b1);
    stop_seq();

    set_rate(12000);
    start_seq(1'b0);
    bit_slot(1'b0, 1'b1, 0);
    stop_seq();

    for (int f = 0; f < 10; f++) begin
      set_rate($urandom_range(540000, 50000));
      start_seq(1'b0);
      for (int i = 0; i < $urandom_range(3, 1); i++)
        bit_slot(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom_range(4, 0));
      if ($urandom_range(1, 0) == 1) begin
        start_seq(1'b1);
        bit_slot(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom_range(4, 0));
      end
      stop_seq();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule